// File: doc/BRIEF.md
# Root Port Status Change Event Generator

This block holds the status registers of a bank of root hub ports for a host controller. Each port tracks whether a device is attached, plus a sticky change flag that records every attach or detach. When a port's change flag rises, the block queues one event record that carries the 1-based number of that port. The records go into a small output FIFO, which stands in for the primary event ring. While the FIFO holds a record, the block raises its single interrupt request, which is interrupt vector 0.

Software reads a port's status at an address computed from the operational base. The operational base is the MMIO base plus the capability length. Software clears the change flag by writing a one to it. A port whose change flag is still set does not queue another record. Only after software clears the flag can the next attach or detach queue a new record.

Each port runs a three-state machine:
- `SLOT_QUIET`: no change is pending.
- `SLOT_PENDING`: a change is pending and its record is not yet queued.
- `SLOT_POSTED`: the record is queued and the port waits for software to clear the flag.

Its transitions are:
- QUIET→PENDING when the change flag is set.
- PENDING→POSTED when the port is granted the FIFO and the flag is still set.
- PENDING→QUIET when the port is granted the FIFO and the flag is already clear.
- POSTED→QUIET when the flag has been cleared.

Top module: `root_port_events`

## Requirements
- R1: After reset, every port status register reads 0 (disconnected, no change pending), `evt_valid` is 0 and `irq` is 0.
- R2: In a status word, bit 0 is "device connected" and bit 1 is "connection changed". An attach on a disconnected port sets both bits on the same clock edge. A detach on a connected port clears bit 0 and sets bit 1. An attach and a detach on the same port in the same cycle have no effect. An attach on a port that is already connected has no effect, and neither does a detach on a port that is already disconnected.
- R3: Port n (1..N_PORTS) is read and written at byte address MMIO_BASE + CAP_LEN + 0x400 + 0x10*(n-1). Any other address reads as 0.
- R4: Each rise of a port's change flag queues exactly one record, and `evt_port` carries the port number, counted from 1.
- R5: While a port's change flag stays set, further attaches or detaches on that port queue no further record. Once software has cleared the flag, the next change queues a new record.
- R6: Writing 1 to bit 1 clears the change flag. Writing 0 to bit 1 leaves it unchanged. Writes never alter bit 0. If a new change and a clear arrive in the same cycle, the change wins.
- R7: When several ports are pending in the same cycle, the lowest-numbered port is queued first.
- R8: When the FIFO is full, pending records are held and not dropped. They are delivered later in port-priority order.
- R9: `irq` is high exactly while the FIFO holds at least one record. A record leaves the FIFO on a cycle where `evt_valid` and `evt_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_attach | input | N_PORTS | Per-port device attach pulse |
| dev_detach | input | N_PORTS | Per-port device detach pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write byte address |
| reg_wr_data | input | DATA_W | Register write data (bit 1 = clear change) |
| reg_rd_addr | input | ADDR_W | Register read byte address |
| reg_rd_data | output | DATA_W | Register read data (combinational) |
| evt_valid | output | 1 | Event record available |
| evt_ready | input | 1 | Consumer takes the record |
| evt_port | output | PID_W | Port number, counted from 1, of the head record |
| irq | output | 1 | Interrupt request, vector 0 |

## Verification
The hardest situation to reach is a full FIFO while several ports are still pending. To get there, the stimulus holds `evt_ready` low, resets the block, and attaches every port in the same cycle. This overfills the two-entry FIFO, so it can be checked that the held ports are later drained in ascending order with nothing lost. A second awkward case is a clear that lands in the same cycle as a new detach. The bench drives both on one negative edge and expects the change flag to survive.

// File: rtl/rpe_pkg.sv
package rpe_pkg;

    typedef enum logic [1:0] {
        SLOT_QUIET   = 2'd0,
        SLOT_PENDING = 2'd1,
        SLOT_POSTED  = 2'd2
    } slot_state_e;

    localparam int STS_CONN_BIT = 0;
    localparam int STS_CHG_BIT  = 1;
    localparam int PORT_WINDOW  = 'h400;
    localparam int PORT_STRIDE  = 'h10;

endpackage

// File: rtl/rpe_port.sv
module rpe_port
    import rpe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic attach,
    input  logic detach,
    input  logic clr_chg,
    input  logic grant,
    output logic conn,
    output logic chg,
    output logic req
);

    slot_state_e state_q, state_d;
    logic        conn_q, chg_q;
    logic        go_conn, go_disc, chg_set;

    assign go_conn = attach && !detach && !conn_q;
    assign go_disc = detach && !attach && conn_q;
    assign chg_set = go_conn || go_disc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            chg_q  <= 1'b0;
        end else begin
            if (go_conn)
                conn_q <= 1'b1;
            else if (go_disc)
                conn_q <= 1'b0;
            if (chg_set)
                chg_q <= 1'b1;
            else if (clr_chg)
                chg_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SLOT_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_QUIET:   if (chg_q) state_d = SLOT_PENDING;
            SLOT_PENDING: if (grant) state_d = chg_q ? SLOT_POSTED : SLOT_QUIET;
            SLOT_POSTED:  if (!chg_q) state_d = SLOT_QUIET;
            default:      state_d = SLOT_QUIET;
        endcase
    end

    always_comb begin
        conn = conn_q;
        chg  = chg_q;
        req  = (state_q == SLOT_PENDING);
    end

endmodule

// File: rtl/rpe_arbiter.sv
module rpe_arbiter #(
    parameter int N_PORTS = 4
) (
    input  logic               en,
    input  logic [N_PORTS-1:0] req,
    output logic [N_PORTS-1:0] grant
);

    logic taken;

    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (en && req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rpe_fifo.sv
module rpe_fifo #(
    parameter int WIDTH = 3,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/root_port_events.sv
module root_port_events
    import rpe_pkg::*;
#(
    parameter int                N_PORTS    = 4,
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 32,
    parameter int                FIFO_DEPTH = 2,
    parameter logic [ADDR_W-1:0] MMIO_BASE  = 16'h1000,
    parameter logic [ADDR_W-1:0] CAP_LEN    = 16'h0020,
    parameter int                PID_W      = $clog2(N_PORTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] dev_attach,
    input  logic [N_PORTS-1:0] dev_detach,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_wr_addr,
    input  logic [DATA_W-1:0]  reg_wr_data,
    input  logic [ADDR_W-1:0]  reg_rd_addr,
    output logic [DATA_W-1:0]  reg_rd_data,
    output logic               evt_valid,
    input  logic               evt_ready,
    output logic [PID_W-1:0]   evt_port,
    output logic               irq
);

    localparam logic [ADDR_W-1:0] OP_BASE = MMIO_BASE + CAP_LEN;

    logic [N_PORTS-1:0] conn_vec, chg_vec, req_vec, grant_vec;
    logic [N_PORTS-1:0] rd_hit, clr_vec;
    logic               evt_push, fifo_full, fifo_empty;
    logic [PID_W-1:0]   push_id;
    logic               wr_data_unused;

    assign wr_data_unused = ^{reg_wr_data[DATA_W-1:STS_CHG_BIT+1], reg_wr_data[STS_CONN_BIT]};

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        localparam logic [ADDR_W-1:0] PADDR =
            OP_BASE + ADDR_W'(PORT_WINDOW) + ADDR_W'(PORT_STRIDE * g);

        assign rd_hit[g]  = (reg_rd_addr == PADDR);
        assign clr_vec[g] = reg_wr_en && (reg_wr_addr == PADDR) && reg_wr_data[STS_CHG_BIT];

        rpe_port i_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .attach  (dev_attach[g]),
            .detach  (dev_detach[g]),
            .clr_chg (clr_vec[g]),
            .grant   (grant_vec[g]),
            .conn    (conn_vec[g]),
            .chg     (chg_vec[g]),
            .req     (req_vec[g])
        );
    end

    always_comb begin
        reg_rd_data = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (rd_hit[i]) begin
                reg_rd_data[STS_CONN_BIT] = conn_vec[i];
                reg_rd_data[STS_CHG_BIT]  = chg_vec[i];
            end
        end
    end

    rpe_arbiter #(.N_PORTS(N_PORTS)) i_arb (
        .en    (!fifo_full),
        .req   (req_vec),
        .grant (grant_vec)
    );

    always_comb begin
        push_id = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (grant_vec[i])
                push_id = PID_W'(i + 1);
        end
    end

    assign evt_push = |grant_vec;

    rpe_fifo #(.WIDTH(PID_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (evt_push),
        .push_data (push_id),
        .pop       (evt_ready),
        .head      (evt_port),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    assign evt_valid = !fifo_empty;
    assign irq       = !fifo_empty;

endmodule

// File: rtl/rpe_chk.sv
module rpe_chk #(
    parameter int                N_PORTS = 4,
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 32,
    parameter int                PID_W   = 3,
    parameter logic [ADDR_W-1:0] OP_BASE = 16'h1020
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PORTS-1:0] attach,
    input logic [N_PORTS-1:0] detach,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [N_PORTS-1:0] conn,
    input logic [N_PORTS-1:0] chg,
    input logic [N_PORTS-1:0] req,
    input logic [N_PORTS-1:0] grant,
    input logic               push,
    input logic               full,
    input logic               evt_valid,
    input logic [PID_W-1:0]   evt_port
);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push); // R8

    AST_PORT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_port >= PID_W'(1) && evt_port <= PID_W'(N_PORTS))); // R4

    for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] PADDR = OP_BASE + ADDR_W'('h400) + ADDR_W'('h10 * g);
        logic hit_clr;
        assign hit_clr = wr_en && (wr_addr == PADDR) && wr_data[1];

        AST_ATTACH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (attach[g] && !detach[g] && !conn[g]) |=> (conn[g] && chg[g])); // R2

        AST_DETACH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (detach[g] && !attach[g] && conn[g]) |=> (!conn[g] && chg[g])); // R2

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_clr && !attach[g] && !detach[g]) |=> !chg[g]); // R6

        AST_CONN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (!attach[g] && !detach[g]) |=> $stable(conn[g])); // R6

        AST_HELD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (req[g] && full) |=> req[g]); // R8

        if (g > 0) begin : g_low
            AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                grant[g] |-> !(|req[g-1:0])); // R7
        end
    end

endmodule

bind root_port_events rpe_chk #(
    .N_PORTS (N_PORTS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PID_W   (PID_W),
    .OP_BASE (MMIO_BASE + CAP_LEN)
) i_rpe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .attach    (dev_attach),
    .detach    (dev_detach),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .conn      (conn_vec),
    .chg       (chg_vec),
    .req       (req_vec),
    .grant     (grant_vec),
    .push      (evt_push),
    .full      (fifo_full),
    .evt_valid (evt_valid),
    .evt_port  (evt_port)
);

// File: tb/test_root_port_events.sv
module test_root_port_events;

    localparam int N = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int PW = 3;
    localparam logic [AW-1:0] BASE = 16'h1000 + 16'h0020;

    typedef struct packed {
        logic [3:0] att;
        logic [3:0] det;
        logic [3:0] clr;
        logic [7:0] sts;   // {p4,p3,p2,p1}, each {chg,conn}
        logic [3:0] evts;  // cumulative records taken
    } step_t;

    localparam step_t STEPS [10] = '{
        '{4'b0001, 4'b0000, 4'b0000, 8'b00_00_00_11, 4'd1}, // R2 R4 attach p1
        '{4'b0000, 4'b0000, 4'b0001, 8'b00_00_00_01, 4'd1}, // R6 clear p1
        '{4'b0110, 4'b0000, 4'b0000, 8'b00_11_11_01, 4'd3}, // R2 R7 p2,p3
        '{4'b0000, 4'b0001, 4'b0000, 8'b00_11_11_10, 4'd4}, // R2 detach p1
        '{4'b0001, 4'b0000, 4'b0000, 8'b00_11_11_11, 4'd4}, // R5 no re-event
        '{4'b0000, 4'b0000, 4'b0111, 8'b00_01_01_01, 4'd4}, // R6 clear three
        '{4'b1000, 4'b1000, 4'b0000, 8'b00_01_01_01, 4'd4}, // R2 both ignored
        '{4'b0001, 4'b0000, 4'b0000, 8'b00_01_01_01, 4'd4}, // R2 redundant attach
        '{4'b0000, 4'b1110, 4'b0000, 8'b00_10_10_01, 4'd6}, // R5 re-armed, p4 ignored
        '{4'b0000, 4'b0000, 4'b0110, 8'b00_00_00_01, 4'd6}  // R6 clear
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dev_attach = '0, dev_detach = '0;
    logic          reg_wr_en = 1'b0;
    logic [AW-1:0] reg_wr_addr = '0, reg_rd_addr = '0;
    logic [DW-1:0] reg_wr_data = '0;
    logic [DW-1:0] reg_rd_data;
    logic          evt_valid, evt_ready = 1'b0, irq;
    logic [PW-1:0] evt_port;

    int n_chk = 0, n_fail = 0, n_taken = 0;
    bit monitor_on = 1'b0;
    int taken_log [16];

    always #5 clk = ~clk;

    root_port_events i_root_port_events (
        .clk(clk), .rst_n(rst_n),
        .dev_attach(dev_attach), .dev_detach(dev_detach),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_port(evt_port), .irq(irq)
    );

    always @(negedge clk) begin
        if (monitor_on && evt_valid && evt_ready) begin
            if (n_taken < 16) taken_log[n_taken] = int'(evt_port);
            n_taken++;
        end
    end

    function automatic logic [AW-1:0] paddr(input int n);
        return BASE + AW'('h400) + AW'('h10 * (n - 1));
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic read_port(input int n, output logic [1:0] v);
        reg_rd_addr = paddr(n);
        #1;
        v = reg_rd_data[1:0];
    endtask

    task automatic write_port(input int n, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = paddr(n); reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        dev_attach = a; dev_detach = d;
        @(negedge clk);
        dev_attach = '0; dev_detach = '0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [1:0] v;
        logic [7:0] all;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int p = 1; p <= N; p++) begin
            read_port(p, v);
            check(v == 2'b00, "R1 status", int'(v), 0);
        end
        check(!evt_valid, "R1 evt_valid", int'(evt_valid), 0);
        check(!irq, "R1 irq", int'(irq), 0);

        // table walk (R2 R4 R5 R6 R7)
        evt_ready = 1'b1;
        monitor_on = 1'b1;
        foreach (STEPS[s]) begin
            pulse(STEPS[s].att, STEPS[s].det);
            for (int p = 1; p <= N; p++)
                if (STEPS[s].clr[p-1]) write_port(p, 32'h2);
            repeat (6) @(negedge clk);
            for (int p = 1; p <= N; p++) begin
                read_port(p, v);
                all[2*(p-1) +: 2] = v;
            end
            check(all == STEPS[s].sts, "R2/R5/R6 table status", int'(all), int'(STEPS[s].sts));
            check(n_taken == int'(STEPS[s].evts), "R4/R5 table records", n_taken, int'(STEPS[s].evts));
        end
        // R7 R4 order of records taken during the walk
        for (int k = 0; k < 6; k++) begin
            int exp_p;
            exp_p = (k % 3) + 1;
            check(taken_log[k] == exp_p, "R7 record order", taken_log[k], exp_p);
        end

        // R3 unmapped addresses read zero (p1 is connected)
        reg_rd_addr = BASE + AW'('h3F0); #1;
        check(reg_rd_data == '0, "R3 below window", int'(reg_rd_data), 0);
        reg_rd_addr = paddr(1) + AW'(4); #1;
        check(reg_rd_data == '0, "R3 off stride", int'(reg_rd_data), 0);
        reg_rd_addr = paddr(N + 1); #1;
        check(reg_rd_data == '0, "R3 past last port", int'(reg_rd_data), 0);
        read_port(1, v);
        check(v == 2'b01, "R3 port1 address", int'(v), 1);

        // R6 write-0, bit0-only writes, then W1C
        pulse(4'b1000, 4'b0000);
        repeat (6) @(negedge clk);
        write_port(4, 32'h0);
        read_port(4, v);
        check(v == 2'b11, "R6 write zero keeps", int'(v), 3);
        write_port(4, 32'h1);
        read_port(4, v);
        check(v == 2'b11, "R6 bit0 write ignored", int'(v), 3);
        write_port(4, 32'h3);
        read_port(4, v);
        check(v == 2'b01, "R6 W1C clears change only", int'(v), 1);
        // R6 set wins over clear in the same cycle
        @(negedge clk);
        dev_detach = 4'b1000;
        reg_wr_en = 1'b1; reg_wr_addr = paddr(4); reg_wr_data = 32'h2;
        @(negedge clk);
        dev_detach = '0; reg_wr_en = 1'b0;
        read_port(4, v);
        check(v == 2'b10, "R6 set beats clear", int'(v), 2);
        repeat (6) @(negedge clk);
        check(!evt_valid && !irq, "R9 drained", int'(irq), 0);

        // R8 R7 full FIFO with all ports pending
        monitor_on = 1'b0;
        evt_ready = 1'b0;
        do_reset();
        for (int p = 1; p <= N; p++) begin
            read_port(p, v);
            check(v == 2'b00, "R1 after reset", int'(v), 0);
        end
        pulse(4'b1111, 4'b0000);
        repeat (12) @(negedge clk);
        check(irq == 1'b1, "R9 irq with records", int'(irq), 1);
        check(evt_port == PW'(1), "R7 head is port1", int'(evt_port), 1);
        for (int k = 1; k <= N; k++) begin
            int w;
            w = 0;
            while (!evt_valid && w < 20) begin
                @(negedge clk);
                w++;
            end
            check(evt_valid && evt_port == PW'(k), "R8 held record", int'(evt_port), k);
            evt_ready = 1'b1;
            @(negedge clk);
            evt_ready = 1'b0;
        end
        repeat (6) @(negedge clk);
        check(!evt_valid, "R8 no extra record", int'(evt_valid), 0);
        check(!irq, "R9 irq low when empty", int'(irq), 0);

        finish_run();
    end

endmodule